// File: doc/BRIEF.md
# Tagged IO translation cache

This block keeps a small fully associative set of IO address translations. Each stored translation is keyed by a virtual page number, a guest context identifier, a process context identifier and a translation-mode tag. The tag records which translation stages were active when the translation was made. A lookup presents a page number, the two context identifiers and the first-stage and second-stage mode fields. The block turns the two mode fields into a tag and answers one cycle later with hit, permission and translated byte address.

A fill port writes a new translation. It takes the lowest-numbered unused slot. When every slot is in use, it overwrites the slot named by a round-robin pointer. An invalidation port clears, in a single cycle, every live entry whose tag equals the given tag. Three independent enables narrow the match by guest context, process context and page number, so all eight combinations of filters are available. Page-table walking, command handling and fault reporting belong to neighbouring blocks.

Top module: `iotc_cache`

## Requirements
- R1: The tag is 2 bits and is derived from the two mode fields, where a mode value of zero means bare. Both bare gives 0 (bypass). First stage active with second stage bare gives 1 (single-stage). First stage bare with second stage active gives 2 (second-stage-only). Both active gives 3 (nested). Any nonzero mode value counts as active. A fill stores the tag derived from its own mode fields.
- R2: A lookup hits only when a live entry has equal page number, guest context, process context and tag. A difference in any one of these gives a miss.
- R3: The response appears on the clock edge after the lookup is presented, with rsp_valid high for exactly one cycle. On a hit, rsp_perm is the stored permission and rsp_pa is the stored physical page shifted left by 12 bits.
- R4: An entry whose permission is 0 (none) never hits. Reset sets every permission to 0.
- R5: An invalidation affects only entries whose stored tag equals inv_tag. Entries of the other tags keep hitting.
- R6: Each of inv_match_gscid, inv_match_pscid and inv_match_vpn, when high, adds equality on that field. An entry is cleared when it meets every enabled condition. With all three low, every entry of the tag is cleared.
- R7: When an invalidation and a lookup arrive in the same cycle, the invalidation takes priority: a lookup that would hit an entry being cleared reports a miss.
- R8: A fill writes the lowest-indexed entry with permission 0. If there is none, it writes the entry at a round-robin pointer, which starts at 0 after reset and advances by one (wrapping) on each such replacement.
- R9: On a miss, rsp_perm and rsp_pa are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | 44 | Lookup virtual page number |
| lkp_gscid | input | 16 | Lookup guest context ID |
| lkp_pscid | input | 20 | Lookup process context ID |
| lkp_s1_mode | input | 4 | Lookup first-stage mode (0 = bare) |
| lkp_s2_mode | input | 4 | Lookup second-stage mode (0 = bare) |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 44 | Fill virtual page number |
| fill_gscid | input | 16 | Fill guest context ID |
| fill_pscid | input | 20 | Fill process context ID |
| fill_s1_mode | input | 4 | Fill first-stage mode |
| fill_s2_mode | input | 4 | Fill second-stage mode |
| fill_ppn | input | 44 | Fill physical page number |
| fill_perm | input | 2 | Fill permission (0 = none) |
| inv_valid | input | 1 | Invalidation request |
| inv_match_gscid | input | 1 | Require guest context equality |
| inv_match_pscid | input | 1 | Require process context equality |
| inv_match_vpn | input | 1 | Require page number equality |
| inv_gscid | input | 16 | Invalidation guest context ID |
| inv_pscid | input | 20 | Invalidation process context ID |
| inv_vpn | input | 44 | Invalidation page number |
| inv_tag | input | 2 | Invalidation tag |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_perm | output | 2 | Permission of the hit entry |
| rsp_pa | output | 56 | Translated byte address |

## Verification
The tag decode is swept over all sixteen pairs of fill tag and lookup tag. This separates the four mode combinations and shows that only the diagonal hits. Single-field perturbations of one stored key show that each key field takes part in the compare. The invalidation filters are swept over all eight enable combinations against eight entries that differ from the key in every subset of the three fields, which tells each enable apart from the others. Tag isolation, same-cycle invalidation against lookup, and the free-slot then round-robin fill order are each checked through the hit pattern of later lookups.

// File: rtl/iotc_pkg.sv
package iotc_pkg;
    typedef enum logic [1:0] {
        TAG_BYPASS = 2'd0,
        TAG_SINGLE = 2'd1,
        TAG_GONLY  = 2'd2,
        TAG_NESTED = 2'd3
    } iotc_tag_e;
endpackage

// File: rtl/iotc_tag_derive.sv
module iotc_tag_derive
    import iotc_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] s1_mode_i,
    input  logic [MODE_W-1:0] s2_mode_i,
    output iotc_tag_e         tag_o
);
    logic s1_on, s2_on;
    assign s1_on = |s1_mode_i;
    assign s2_on = |s2_mode_i;

    always_comb begin
        unique case ({s1_on, s2_on})
            2'b00:   tag_o = TAG_BYPASS;
            2'b10:   tag_o = TAG_SINGLE;
            2'b01:   tag_o = TAG_GONLY;
            default: tag_o = TAG_NESTED;
        endcase
    end
endmodule

// File: rtl/iotc_match.sv
module iotc_match
    import iotc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 44,
    parameter int GSCID_W = 16,
    parameter int PSCID_W = 20,
    parameter int PERM_W  = 2
) (
    input  logic [VPN_W-1:0]   ent_vpn_i   [ENTRIES],
    input  logic [GSCID_W-1:0] ent_gscid_i [ENTRIES],
    input  logic [PSCID_W-1:0] ent_pscid_i [ENTRIES],
    input  iotc_tag_e          ent_tag_i   [ENTRIES],
    input  logic [PERM_W-1:0]  ent_perm_i  [ENTRIES],
    input  logic [VPN_W-1:0]   lkp_vpn_i,
    input  logic [GSCID_W-1:0] lkp_gscid_i,
    input  logic [PSCID_W-1:0] lkp_pscid_i,
    input  iotc_tag_e          lkp_tag_i,
    input  logic               inv_valid_i,
    input  logic               inv_use_g_i,
    input  logic               inv_use_p_i,
    input  logic               inv_use_v_i,
    input  logic [VPN_W-1:0]   inv_vpn_i,
    input  logic [GSCID_W-1:0] inv_gscid_i,
    input  logic [PSCID_W-1:0] inv_pscid_i,
    input  iotc_tag_e          inv_tag_i,
    output logic [ENTRIES-1:0] lkp_hit_o,
    output logic [ENTRIES-1:0] inv_hit_o
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic live;
        assign live = ent_perm_i[e] != '0;
        assign lkp_hit_o[e] = live
                           && (ent_tag_i[e]   == lkp_tag_i)
                           && (ent_gscid_i[e] == lkp_gscid_i)
                           && (ent_pscid_i[e] == lkp_pscid_i)
                           && (ent_vpn_i[e]   == lkp_vpn_i);
        assign inv_hit_o[e] = inv_valid_i && live
                           && (ent_tag_i[e] == inv_tag_i)
                           && (!inv_use_g_i || ent_gscid_i[e] == inv_gscid_i)
                           && (!inv_use_p_i || ent_pscid_i[e] == inv_pscid_i)
                           && (!inv_use_v_i || ent_vpn_i[e]   == inv_vpn_i);
    end
endmodule

// File: rtl/iotc_victim.sv
module iotc_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] free_i,
    input  logic               fill_i,
    output logic [IDX_W-1:0]   victim_o
);
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_o = free_found ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_i && !free_found) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/iotc_cache.sv
module iotc_cache
    import iotc_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int VPN_W      = 44,
    parameter int PPN_W      = 44,
    parameter int GSCID_W    = 16,
    parameter int PSCID_W    = 20,
    parameter int PERM_W     = 2,
    parameter int MODE_W     = 4,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid,
    input  logic [VPN_W-1:0]   lkp_vpn,
    input  logic [GSCID_W-1:0] lkp_gscid,
    input  logic [PSCID_W-1:0] lkp_pscid,
    input  logic [MODE_W-1:0]  lkp_s1_mode,
    input  logic [MODE_W-1:0]  lkp_s2_mode,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [GSCID_W-1:0] fill_gscid,
    input  logic [PSCID_W-1:0] fill_pscid,
    input  logic [MODE_W-1:0]  fill_s1_mode,
    input  logic [MODE_W-1:0]  fill_s2_mode,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic [PERM_W-1:0]  fill_perm,
    input  logic               inv_valid,
    input  logic               inv_match_gscid,
    input  logic               inv_match_pscid,
    input  logic               inv_match_vpn,
    input  logic [GSCID_W-1:0] inv_gscid,
    input  logic [PSCID_W-1:0] inv_pscid,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic [1:0]         inv_tag,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PERM_W-1:0]  rsp_perm,
    output logic [PA_W-1:0]    rsp_pa
);
    logic [VPN_W-1:0]   vpn_q   [ENTRIES];
    logic [PPN_W-1:0]   ppn_q   [ENTRIES];
    logic [GSCID_W-1:0] gscid_q [ENTRIES];
    logic [PSCID_W-1:0] pscid_q [ENTRIES];
    iotc_tag_e          tag_q   [ENTRIES];
    logic [PERM_W-1:0]  perm_q  [ENTRIES];

    iotc_tag_e          lkp_tag, fill_tag;
    logic [ENTRIES-1:0] lkp_hit_vec, inv_hit_vec, free_vec, eff_hit_vec;
    logic [IDX_W-1:0]   victim;

    logic               rsp_valid_q, rsp_hit_q;
    logic [PERM_W-1:0]  rsp_perm_q;
    logic [PPN_W-1:0]   rsp_ppn_q;

    iotc_tag_derive #(.MODE_W(MODE_W)) lkp_tag_i (
        .s1_mode_i(lkp_s1_mode), .s2_mode_i(lkp_s2_mode), .tag_o(lkp_tag));
    iotc_tag_derive #(.MODE_W(MODE_W)) fill_tag_i (
        .s1_mode_i(fill_s1_mode), .s2_mode_i(fill_s2_mode), .tag_o(fill_tag));

    iotc_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .GSCID_W(GSCID_W),
        .PSCID_W(PSCID_W), .PERM_W(PERM_W)
    ) match_i (
        .ent_vpn_i(vpn_q), .ent_gscid_i(gscid_q), .ent_pscid_i(pscid_q),
        .ent_tag_i(tag_q), .ent_perm_i(perm_q),
        .lkp_vpn_i(lkp_vpn), .lkp_gscid_i(lkp_gscid), .lkp_pscid_i(lkp_pscid),
        .lkp_tag_i(lkp_tag),
        .inv_valid_i(inv_valid), .inv_use_g_i(inv_match_gscid),
        .inv_use_p_i(inv_match_pscid), .inv_use_v_i(inv_match_vpn),
        .inv_vpn_i(inv_vpn), .inv_gscid_i(inv_gscid), .inv_pscid_i(inv_pscid),
        .inv_tag_i(iotc_tag_e'(inv_tag)),
        .lkp_hit_o(lkp_hit_vec), .inv_hit_o(inv_hit_vec)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_free
        assign free_vec[e] = perm_q[e] == '0;
    end

    iotc_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk(clk), .rst_n(rst_n), .free_i(free_vec),
        .fill_i(fill_valid), .victim_o(victim));

    // invalidation in the same cycle suppresses the hit
    assign eff_hit_vec = lkp_hit_vec & ~inv_hit_vec;

    // entry storage: invalidation clears, fill writes its slot afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                perm_q[e]  <= '0;
                vpn_q[e]   <= '0;
                ppn_q[e]   <= '0;
                gscid_q[e] <= '0;
                pscid_q[e] <= '0;
                tag_q[e]   <= TAG_BYPASS;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (inv_hit_vec[e]) begin
                    perm_q[e] <= '0;
                end
                if (fill_valid && victim == IDX_W'(e)) begin
                    perm_q[e]  <= fill_perm;
                    vpn_q[e]   <= fill_vpn;
                    ppn_q[e]   <= fill_ppn;
                    gscid_q[e] <= fill_gscid;
                    pscid_q[e] <= fill_pscid;
                    tag_q[e]   <= fill_tag;
                end
            end
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_perm_q  <= '0;
            rsp_ppn_q   <= '0;
        end else begin
            rsp_valid_q <= lkp_valid;
            rsp_hit_q   <= 1'b0;
            rsp_perm_q  <= '0;
            rsp_ppn_q   <= '0;
            if (lkp_valid) begin
                for (int e = ENTRIES - 1; e >= 0; e--) begin
                    if (eff_hit_vec[e]) begin
                        rsp_hit_q  <= 1'b1;
                        rsp_perm_q <= perm_q[e];
                        rsp_ppn_q  <= ppn_q[e];
                    end
                end
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_perm  = rsp_perm_q;
    assign rsp_pa    = {rsp_ppn_q, {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/iotc_cache_chk.sv
module iotc_cache_chk #(
    parameter int PERM_W     = 2,
    parameter int PAGE_SHIFT = 12,
    parameter int PA_W       = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lkp_valid,
    input logic [1:0]        lkp_tag,
    input logic              inv_valid,
    input logic              inv_match_gscid,
    input logic              inv_match_pscid,
    input logic              inv_match_vpn,
    input logic [1:0]        inv_tag,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PERM_W-1:0] rsp_perm,
    input logic [PA_W-1:0]   rsp_pa
);
    // R3
    rsp_follows_lkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);
    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);
    // R3
    pa_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[PAGE_SHIFT-1:0] == '0);
    // R2
    hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_perm != '0));
    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == '0 && rsp_pa == '0));
    // R7
    inv_beats_lkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_match_gscid && !inv_match_pscid && !inv_match_vpn
         && lkp_valid && lkp_tag == inv_tag) |=> !rsp_hit);
endmodule

bind iotc_cache iotc_cache_chk #(
    .PERM_W(PERM_W), .PAGE_SHIFT(PAGE_SHIFT), .PA_W(PA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_tag(lkp_tag),
    .inv_valid(inv_valid), .inv_match_gscid(inv_match_gscid),
    .inv_match_pscid(inv_match_pscid), .inv_match_vpn(inv_match_vpn),
    .inv_tag(inv_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_perm(rsp_perm), .rsp_pa(rsp_pa)
);

// File: tb/iotc_cache_tb_top.sv
module iotc_cache_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        lkp_valid = 0;
    logic [43:0] lkp_vpn = '0;
    logic [15:0] lkp_gscid = '0;
    logic [19:0] lkp_pscid = '0;
    logic [3:0]  lkp_s1_mode = '0, lkp_s2_mode = '0;
    logic        fill_valid = 0;
    logic [43:0] fill_vpn = '0, fill_ppn = '0;
    logic [15:0] fill_gscid = '0;
    logic [19:0] fill_pscid = '0;
    logic [3:0]  fill_s1_mode = '0, fill_s2_mode = '0;
    logic [1:0]  fill_perm = '0;
    logic        inv_valid = 0, inv_match_gscid = 0, inv_match_pscid = 0, inv_match_vpn = 0;
    logic [15:0] inv_gscid = '0;
    logic [19:0] inv_pscid = '0;
    logic [43:0] inv_vpn = '0;
    logic [1:0]  inv_tag = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_perm;
    logic [55:0] rsp_pa;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    iotc_cache dut_i (.*);

    localparam logic [43:0] VB = 44'hA5C_1234_5670;
    localparam logic [43:0] PB = 44'h3D0_0000_0100;
    localparam logic [15:0] GB = 16'h1C2D;
    localparam logic [19:0] SB = 20'h4_0A0B;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    // tag t -> modes: bit0 first stage active, bit1 second stage active
    task automatic fill(logic [43:0] v, logic [15:0] g, logic [19:0] s, int t,
                        logic [43:0] p, logic [1:0] pm);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_gscid = g; fill_pscid = s;
        fill_s1_mode = t[0] ? 4'd8 : 4'd0; fill_s2_mode = t[1] ? 4'd8 : 4'd0;
        fill_ppn = p; fill_perm = pm;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic set_lkp(logic [43:0] v, logic [15:0] g, logic [19:0] s, int t);
        lkp_valid = 1; lkp_vpn = v; lkp_gscid = g; lkp_pscid = s;
        lkp_s1_mode = t[0] ? 4'd9 : 4'd0; lkp_s2_mode = t[1] ? 4'd6 : 4'd0;
    endtask

    task automatic look(logic [43:0] v, logic [15:0] g, logic [19:0] s, int t);
        @(negedge clk);
        set_lkp(v, g, s, t);
        @(negedge clk);
        lkp_valid = 0;
    endtask

    task automatic set_inv(bit ug, bit us, bit uv, logic [43:0] v,
                           logic [15:0] g, logic [19:0] s, int t);
        inv_valid = 1; inv_match_gscid = ug; inv_match_pscid = us; inv_match_vpn = uv;
        inv_vpn = v; inv_gscid = g; inv_pscid = s; inv_tag = 2'(t);
    endtask

    task automatic inval(bit ug, bit us, bit uv, logic [43:0] v,
                         logic [15:0] g, logic [19:0] s, int t);
        @(negedge clk);
        set_inv(ug, us, uv, v, g, s, t);
        @(negedge clk);
        inv_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R4: reset state, no response without lookup
        @(negedge clk);
        chk("R3 idle rsp_valid", 64'(rsp_valid), 0);
        look(VB, GB, SB, 0);
        chk("R4 miss after reset", 64'(rsp_hit), 0);
        chk("R3 rsp_valid after lookup", 64'(rsp_valid), 1);
        chk("R9 perm on miss", 64'(rsp_perm), 0);
        chk("R9 pa on miss", 64'(rsp_pa), 0);
        @(negedge clk);
        chk("R3 rsp_valid one cycle", 64'(rsp_valid), 0);

        // R1: fill with each tag, lookup with each tag
        for (int ft = 0; ft < 4; ft++) begin
            do_reset();
            fill(VB, GB, SB, ft, PB + 44'(ft), 2'(ft % 3 + 1));
            for (int lt = 0; lt < 4; lt++) begin
                look(VB, GB, SB, lt);
                chk($sformatf("R1 tag fill=%0d lkp=%0d hit", ft, lt), 64'(rsp_hit), 64'(ft == lt));
                if (ft == lt) begin
                    chk("R3 pa", 64'(rsp_pa), 64'(PB + 44'(ft)) << 12);
                    chk("R3 perm", 64'(rsp_perm), 64'(ft % 3 + 1));
                end
            end
        end

        // R2: single field perturbation
        do_reset();
        fill(VB, GB, SB, 3, PB, 2'd3);
        look(VB, GB, SB, 3);
        chk("R2 exact key hit", 64'(rsp_hit), 1);
        look(VB ^ 44'h1, GB, SB, 3);
        chk("R2 vpn differs", 64'(rsp_hit), 0);
        look(VB, GB ^ 16'h8000, SB, 3);
        chk("R2 gscid differs", 64'(rsp_hit), 0);
        look(VB, GB, SB ^ 20'h1, 3);
        chk("R2 pscid differs", 64'(rsp_hit), 0);
        chk("R9 pa on miss", 64'(rsp_pa), 0);
        look(VB, GB, SB, 2);
        chk("R2 tag differs", 64'(rsp_hit), 0);

        // R5: invalidate-all of one tag leaves the others
        do_reset();
        for (int t = 0; t < 4; t++) fill(VB, GB, SB, t, PB, 2'd1);
        inval(0, 0, 0, '0, '0, '0, 2);
        for (int t = 0; t < 4; t++) begin
            look(VB, GB, SB, t);
            chk($sformatf("R5 tag %0d after clearing tag 2", t), 64'(rsp_hit), 64'(t != 2));
        end

        // R6: all eight filter combinations against eight key variants
        for (int m = 0; m < 8; m++) begin
            do_reset();
            for (int e = 0; e < 8; e++)
                fill(e[2] ? VB + 44'h10 : VB, e[0] ? GB + 16'd1 : GB,
                     e[1] ? SB + 20'd1 : SB, 3, PB + 44'(e), 2'd2);
            inval(m[0], m[1], m[2], VB, GB, SB, 3);
            for (int e = 0; e < 8; e++) begin
                bit killed;
                killed = !(m[0] && e[0]) && !(m[1] && e[1]) && !(m[2] && e[2]);
                look(e[2] ? VB + 44'h10 : VB, e[0] ? GB + 16'd1 : GB,
                     e[1] ? SB + 20'd1 : SB, 3);
                chk($sformatf("R6 mask=%0d entry=%0d hit", m, e), 64'(rsp_hit), 64'(!killed));
            end
        end

        // R7: invalidation and lookup in the same cycle
        do_reset();
        fill(VB, GB, SB, 1, PB, 2'd3);
        fill(VB + 44'h20, GB, SB, 1, PB + 44'h1, 2'd3);
        @(negedge clk);
        set_inv(0, 0, 1, VB, GB, SB, 1);
        set_lkp(VB, GB, SB, 1);
        @(negedge clk);
        inv_valid = 0; lkp_valid = 0;
        chk("R7 same-cycle invalidation wins", 64'(rsp_hit), 0);
        look(VB, GB, SB, 1);
        chk("R7 entry stays cleared", 64'(rsp_hit), 0);
        @(negedge clk);
        set_inv(0, 0, 1, VB, GB, SB, 1);
        set_lkp(VB + 44'h20, GB, SB, 1);
        @(negedge clk);
        inv_valid = 0; lkp_valid = 0;
        chk("R7 unrelated lookup still hits", 64'(rsp_hit), 1);

        // R8: free slots first, then round robin from 0
        do_reset();
        for (int e = 0; e < 8; e++) fill(VB + 44'(e), GB, SB, 0, PB, 2'd1);
        fill(VB + 44'd8, GB, SB, 0, PB, 2'd1);
        fill(VB + 44'd9, GB, SB, 0, PB, 2'd1);
        look(VB, GB, SB, 0);
        chk("R8 slot0 replaced", 64'(rsp_hit), 0);
        look(VB + 44'd1, GB, SB, 0);
        chk("R8 slot1 replaced", 64'(rsp_hit), 0);
        look(VB + 44'd2, GB, SB, 0);
        chk("R8 slot2 kept", 64'(rsp_hit), 1);
        look(VB + 44'd9, GB, SB, 0);
        chk("R8 newest present", 64'(rsp_hit), 1);
        inval(0, 0, 1, VB + 44'd5, GB, SB, 0);
        fill(VB + 44'd10, GB, SB, 0, PB, 2'd1);
        look(VB + 44'd2, GB, SB, 0);
        chk("R8 free slot used before pointer", 64'(rsp_hit), 1);
        look(VB + 44'd10, GB, SB, 0);
        chk("R8 refill present", 64'(rsp_hit), 1);
        fill(VB + 44'd11, GB, SB, 0, PB, 2'd1);
        look(VB + 44'd2, GB, SB, 0);
        chk("R8 pointer resumes at slot2", 64'(rsp_hit), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule